// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 9-bit fully differential, binary-weighted charge-redistribution converter. A start pulse opens one sampling cycle. The block then walks a binary search from the most significant bit down to the least significant bit. On each cycle it presents a trial bottom-plate switch code to each capacitor bank and takes one decision bit from the comparator. When the last bit is fixed, it publishes the result together with a one-cycle done strobe.

The top bit is already set while the input is being sampled. Because of this, the first comparison needs no extra switching cycle, and a conversion takes exactly ten clock cycles from sampling to the last decision. The two banks always receive complementary codes. The capacitor array, the comparator and the sampling switches sit outside this block.

Top module: `sar_seq`

## Requirements
- R1: `result_o` is the binary-search outcome. Bit b of the result is 1 exactly when `cmp_i` was high during the cycle in which bit b was on trial. With a comparator that reports 1 when the input code is greater than or equal to the trial code, the result equals the input code.
- R2: When `start_i` is high at a rising edge while idle, `sample_o` is high for exactly the following cycle. `done_o` rises at the tenth rising edge after the one that took the start.
- R3: During the sampling cycle, `swp_o` is 9'b1_0000_0000 (bit 8, the MSB, set and all others clear).
- R4: In the k-th compare cycle (k = 1..9), the trial bit is b = 9-k. `swp_o` carries the already decided bits above b, a 1 at bit b, and zeros below b.
- R5: `swn_o` is the bitwise complement of `swp_o` at all times.
- R6: `done_o` is high for exactly one cycle per conversion. `result_o` changes only at the edge where `done_o` rises, and otherwise holds its value.
- R7: A `start_i` pulse that arrives while a conversion is in progress has no effect. Neither the result nor the done timing changes.
- R8: While `rst_ni` is low, the block is idle with `sample_o` low, `swp_o` at 9'b1_0000_0000, `done_o` low and `result_o` zero. A reset in mid-conversion aborts the conversion.
- R9: A start given in the cycle in which `done_o` is high is accepted, so conversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| cmp_i | input | 1 | Comparator decision, 1 when the residue is above zero |
| sample_o | output | 1 | Input sampling enable |
| swp_o | output | 9 | Bottom-plate switch code, positive bank |
| swn_o | output | 9 | Bottom-plate switch code, negative bank |
| done_o | output | 1 | One-cycle conversion-complete strobe |
| result_o | output | 9 | Last conversion result |

## Verification
A wrong phase pointer or decision register shows up on `swp_o` in the very next cycle, because the trial code is exposed at the ports every cycle. The bench compares that code with a behavioural binary search on every clock, so a bit kept or dropped by mistake appears within one cycle, long before the result is published. A wrong phase count instead moves `done_o` off the tenth edge, or stretches `sample_o`, and is caught in the cycle where the two timelines diverge. Inputs at the code extremes and alternating bit patterns make sure every trial bit is seen both kept and cleared.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             sample_o,
  output logic             conv_o,
  output logic             last_o,
  output logic [WIDTH-1:0] ptr_o
);
  localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_e       state_q;
  logic [WIDTH-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_SAMP;
        ST_SAMP: begin
          state_q <= ST_CONV;
          ptr_q   <= MSB;
        end
        ST_CONV: begin
          if (ptr_q[0]) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
          end else begin
            ptr_q <= ptr_q >> 1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sample_o = (state_q == ST_SAMP);
  assign conv_o   = (state_q == ST_CONV);
  assign last_o   = conv_o & ptr_q[0];
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/sar_seq_sar.sv
module sar_seq_sar #(
  parameter int WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  input  logic             last_i,
  input  logic [WIDTH-1:0] ptr_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);
  localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] code_q, res_q, decided, code_nxt;
  logic             done_q;

  // keep or drop the bit on trial, then arm the next lower one
  assign decided  = (code_q & ~ptr_i) | (cmp_i ? ptr_i : '0);
  assign code_nxt = last_i ? MSB : (decided | (ptr_i >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= MSB;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (conv_i) begin
        code_q <= code_nxt;
        if (last_i) begin
          res_q  <= decided;
          done_q <= 1'b1;
        end
      end else begin
        code_q <= MSB;
      end
    end
  end

  assign code_o   = code_q;
  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sar_seq_drv.sv
module sar_seq_drv #(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] code_i,
  output logic [WIDTH-1:0] swp_o,
  output logic [WIDTH-1:0] swn_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bank
    assign swp_o[i] = code_i[i];
    assign swn_o[i] = ~code_i[i];
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             sample_o,
  output logic [WIDTH-1:0] swp_o,
  output logic [WIDTH-1:0] swn_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  logic             conv, last;
  logic [WIDTH-1:0] ptr, code;

  sar_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .sample_o(sample_o),
    .conv_o  (conv),
    .last_o  (last),
    .ptr_o   (ptr)
  );

  sar_seq_sar #(.WIDTH(WIDTH)) u_sar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .conv_i  (conv),
    .last_i  (last),
    .ptr_i   (ptr),
    .cmp_i   (cmp_i),
    .code_o  (code),
    .result_o(result_o),
    .done_o  (done_o)
  );

  sar_seq_drv #(.WIDTH(WIDTH)) u_drv (
    .code_i(code),
    .swp_o (swp_o),
    .swn_o (swn_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int WIDTH = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_o,
  input logic [WIDTH-1:0] swp_o,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};
  localparam int CW = $clog2(WIDTH + 2) + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (sample_o)        cnt_q <= CW'(1);
    else if (done_o)          cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q + CW'(1);
  end

  a_r2_sample_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
  a_r2_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_q == CW'(WIDTH + 1));
  a_r3_sample_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> swp_o == MSB);
  a_r4_first_trial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> swp_o == MSB);
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

bind sar_seq sar_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sample_o(sample_o),
  .swp_o   (swp_o),
  .done_o  (done_o),
  .result_o(result_o)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] vin = '0;
  logic         cmp, sample, done;
  logic [W-1:0] swp, swn, result;
  int           total = 0, bad = 0;
  bit           finished = 0;

  always #10 clk = ~clk;

  // behavioural comparator: residue above zero when input >= trial code
  assign cmp = (vin >= swp);

  sar_seq #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .sample_o(sample), .swp_o(swp), .swn_o(swn), .done_o(done), .result_o(result)
  );

  // reference timeline: ph -1 idle, 0 sampling, 1..9 compare cycles
  int ph = -1;
  bit exp_done = 0;
  int exp_res = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = -1; exp_done = 0; exp_res = 0;
    end else begin
      exp_done = 0;
      if (ph == -1) begin
        if (start) ph = 0;
      end else if (ph < W) ph = ph + 1;
      else begin
        ph = -1; exp_done = 1; exp_res = int'(vin);
      end
    end
  end

  function automatic int exp_code();
    int b, mask;
    if (ph <= 0) return 1 << (W - 1);
    b = W - ph;
    mask = ~((1 << (b + 1)) - 1) & ((1 << W) - 1);
    return (int'(vin) & mask) | (1 << b);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk(sample == (ph == 0), "R2 sample_o", int'(sample), int'(ph == 0));
      chk(int'(swp) == exp_code(), ph == 0 ? "R3 swp_o sampling" : "R4 swp_o trial",
          int'(swp), exp_code());
      chk(swn == ~swp, "R5 swn_o complement", int'(swn), int'(~swp));
      chk(done == exp_done, "R6 done_o", int'(done), int'(exp_done));
      chk(int'(result) == exp_res, "R6 result_o", int'(result), exp_res);
    end
  end

  // all tasks enter and leave 2 ns after a falling edge
  task automatic convert(int v, string tag);
    vin = W'(v);
    start = 1'b1;
    @(negedge clk); #2;
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(done == 1'b1, {tag, " done at tenth edge"}, int'(done), 1);
    chk(int'(result) == v, {tag, " result"}, int'(result), v);
    #2;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sample == 1'b0 && done == 1'b0, "R8 reset idle", int'(sample), 0);
    chk(swp == 9'h100, "R8 reset code", int'(swp), 256);
    chk(result == '0, "R8 reset result", int'(result), 0);
    #2 rst_n = 1'b1;
    idle(2);

    convert(0, "R1");
    idle(1);
    convert(511, "R1");
    idle(2);
    convert(256, "R1");
    convert(255, "R9");
    convert(170, "R9");
    idle(1);
    convert(341, "R1");
    idle(3);
    convert(1, "R1");
    idle(1);

    // R7: extra start mid-conversion
    vin = 9'd93;
    start = 1'b1;
    @(negedge clk); #2;
    start = 1'b0;
    repeat (3) @(negedge clk); #2;
    start = 1'b1;
    @(negedge clk); #2;
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(done == 1'b1, "R7 done timing kept", int'(done), 1);
    chk(result == 9'd93, "R7 result", int'(result), 93);
    #2;
    idle(3);
    chk(sample == 1'b0, "R7 no restart", int'(sample), 0);

    // R8: reset mid-conversion
    vin = 9'd300;
    start = 1'b1;
    @(negedge clk); #2;
    start = 1'b0;
    repeat (4) @(negedge clk); #2;
    rst_n = 1'b0;
    @(negedge clk);
    chk(sample == 1'b0 && done == 1'b0, "R8 abort idle", int'(sample), 0);
    chk(swp == 9'h100, "R8 abort code", int'(swp), 256);
    chk(result == '0, "R8 abort result", int'(result), 0);
    #2 rst_n = 1'b1;
    idle(2);
    convert(300, "R1");
    idle(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule